// File: doc/BRIEF.md
# SDRAM Single-Bank Burst Engine with Clock-Enable Suspend

The block is a synthesizable device-side model of one SDRAM bank. It takes decoded commands, opens and closes a row, and runs fixed four-beat read and write bursts against a small internal column array. Reads return data after a CAS latency of two cycles. Writes take their first word in the same cycle as the command.

A clock-enable input can freeze the engine. It is sampled on every edge. When it is seen low while the row is open, a registered suspend flag sets. From the following edge onward, nothing advances: the read latency pipeline, the beat counter, the column counter and the command decoder all hold. The read output stays on its last word, and write data presented during the freeze is discarded. The first edge at which clock-enable is seen high again is still frozen, and operation resumes on the edge after it. With the row closed, clock-enable has no effect.

Top module: `sdr_burst_engine`

## Requirements
- R1: After reset, dout_valid_o is 0, the row is closed and the engine is not suspended.
- R2: Command codes on cmd_i are 0 no-op, 1 open row, 2 read, 3 write and 4 close row; any other code acts as a no-op. A read or write issued while the row is closed is ignored.
- R3: A read accepted at edge T0 drives its first word on dout_o after edge T2, then three further words on consecutive edges. dout_valid_o is high for exactly those four cycles and low afterwards.
- R4: A write accepted at edge T0 stores din_i from that edge as beat 0. It stores din_i from the next three advancing edges as beats 1 to 3.
- R5: Beat i of a burst that starts at column c uses column {c[3:2], (c[1:0]+i) mod 4}. The sequence wraps inside an aligned group of four.
- R6: If clock-enable is sampled low at edge E while the row is open, edge E still advances normally, including command decode. The edges after E are frozen.
- R7: The first edge at which clock-enable is sampled high again is still frozen, and the next edge advances. A run of N low samples therefore freezes exactly N edges, so no beat is lost or repeated.
- R8: While frozen, dout_o and dout_valid_o hold their values, and a frozen read burst continues with its remaining beats after the exit.
- R9: din_i presented on a frozen edge is not written. The frozen write burst stores its remaining beats on the following advancing edges.
- R10: Any command presented on a frozen edge is ignored. This includes open row, close row, read and write.
- R11: Clock-enable low while the row is closed causes no freeze, and commands are still decoded.
- R12: Open row, close row, read and write presented while a burst is in progress are ignored. A new read or write is accepted only when the engine is idle and not frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cke_i | input | 1 | Clock enable, sampled every edge |
| cmd_i | input | 3 | Decoded command code |
| col_i | input | COL_W (4) | Starting column of a read or write |
| din_i | input | DATA_W (16) | Write data |
| dout_o | output | DATA_W (16) | Read data |
| dout_valid_o | output | 1 | Read data valid |

## Verification
The hardest situation to reach is a freeze that starts or ends on a particular beat of a burst. The cases include a freeze on the very edge that accepts a read, one in the middle of a write, and one that spans the final fetch. The stimulus uses burst tasks that take a start edge and a length for the low run of clock-enable. Expected outputs come from counting advancing edges: a read word is due once the count reaches the latency, and a write beat is consumed only on advancing edges. Commands that must be dropped are placed on frozen and busy edges. Read-backs then show that the row and memory were left unchanged.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WR   = 2'd2
  } seq_e;
endpackage

// File: rtl/sdr_cke_gate.sv
module sdr_cke_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  input  logic row_open_i,
  output logic adv_o
);
  logic susp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) susp_q <= 1'b0;
    else         susp_q <= !cke_i && row_open_i;
  end

  assign adv_o = !susp_q;

  p_no_susp_closed_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!row_open_i && !susp_q) |=> !susp_q);
  p_exit_one_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_q && cke_i) |=> adv_o);
  p_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && !cke_i && row_open_i) |=> !adv_o);
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_pkg::*;
#(
  parameter int COL_W     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  cmd_e             cmd_i,
  input  logic [COL_W-1:0] col_i,
  output logic             row_open_o,
  output logic             rd_fetch_o,
  output logic             wr_en_o,
  output logic [COL_W-1:0] addr_o
);
  localparam int BL_W = $clog2(BURST_LEN);
  localparam logic [BL_W-1:0] LAST_BEAT = BL_W'(BURST_LEN - 1);

  seq_e             state_q;
  logic [BL_W-1:0]  beat_q;
  logic [COL_W-1:0] col_q;
  logic             row_q;

  function automatic logic [COL_W-1:0] col_inc(input logic [COL_W-1:0] c);
    logic [BL_W-1:0] lo;
    lo = c[BL_W-1:0] + BL_W'(1);
    return {c[COL_W-1:BL_W], lo};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      beat_q  <= '0;
      col_q   <= '0;
      row_q   <= 1'b0;
    end else if (adv_i) begin
      unique case (state_q)
        SEQ_IDLE: begin
          unique case (cmd_i)
            CMD_ACT: row_q <= 1'b1;
            CMD_PRE: row_q <= 1'b0;
            CMD_RD: if (row_q) begin
              state_q <= SEQ_RD;
              beat_q  <= '0;
              col_q   <= col_i;
            end
            CMD_WR: if (row_q) begin
              state_q <= SEQ_WR;
              beat_q  <= BL_W'(1);
              col_q   <= col_inc(col_i);
            end
            default: ;
          endcase
        end
        SEQ_RD, SEQ_WR: begin
          col_q  <= col_inc(col_q);
          beat_q <= beat_q + BL_W'(1);
          if (beat_q == LAST_BEAT) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // beat 0 of a write is taken with the command itself
  always_comb begin
    rd_fetch_o = adv_i && (state_q == SEQ_RD);
    wr_en_o    = adv_i && ((state_q == SEQ_WR) ||
                           (state_q == SEQ_IDLE && cmd_i == CMD_WR && row_q));
    addr_o     = (state_q == SEQ_IDLE) ? col_i : col_q;
    row_open_o = row_q;
  end

  p_freeze_counters_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != SEQ_IDLE && !adv_i) |=> ($stable(beat_q) && $stable(col_q)));
  p_freeze_cmds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(row_q) && $stable(state_q)));
  p_busy_no_abort_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_RD && adv_i && beat_q != LAST_BEAT) |=> (state_q == SEQ_RD && row_q));
  p_rw_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_fetch_o && wr_en_o));
endmodule

// File: rtl/sdr_data_path.sv
module sdr_data_path #(
  parameter int DATA_W   = 16,
  parameter int NUM_COLS = 16,
  parameter int CAS_LAT  = 2,
  parameter int COL_W    = $clog2(NUM_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              rd_fetch_i,
  input  logic              wr_en_i,
  input  logic [COL_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_valid_o
);
  localparam int NSTG = CAS_LAT - 1;

  logic [DATA_W-1:0] mem_q [NUM_COLS];
  logic [DATA_W-1:0] dout_q;
  logic              dvld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_COLS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[addr_i] <= din_i;
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (adv_i) begin
          v_q <= rd_fetch_i;
          d_q <= mem_q[addr_i];
        end
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (adv_i) begin
          v_q <= g_stg[s-1].v_q;
          d_q <= g_stg[s-1].d_q;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dvld_q <= 1'b0;
    end else if (adv_i) begin
      dout_q <= g_stg[NSTG-1].d_q;
      dvld_q <= g_stg[NSTG-1].v_q;
    end
  end

  assign dout_o       = dout_q;
  assign dout_valid_o = dvld_q;

  p_hold_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(dout_o) && $stable(dout_valid_o)));
  p_mask_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> adv_i);
  p_fetch_advancing_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fetch_i |-> adv_i);
endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
  import sdr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_COLS  = 16,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 2,
  parameter int COL_W     = $clog2(NUM_COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic [2:0]        cmd_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_valid_o
);
  logic             adv;
  logic             row_open;
  logic             rd_fetch;
  logic             wr_en;
  logic [COL_W-1:0] addr;

  sdr_cke_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cke_i      (cke_i),
    .row_open_i (row_open),
    .adv_o      (adv)
  );

  sdr_burst_seq #(
    .COL_W     (COL_W),
    .BURST_LEN (BURST_LEN)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .cmd_i      (cmd_e'(cmd_i)),
    .col_i      (col_i),
    .row_open_o (row_open),
    .rd_fetch_o (rd_fetch),
    .wr_en_o    (wr_en),
    .addr_o     (addr)
  );

  sdr_data_path #(
    .DATA_W   (DATA_W),
    .NUM_COLS (NUM_COLS),
    .CAS_LAT  (CAS_LAT),
    .COL_W    (COL_W)
  ) u_dp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .adv_i        (adv),
    .rd_fetch_i   (rd_fetch),
    .wr_en_i      (wr_en),
    .addr_i       (addr),
    .din_i        (din_i),
    .dout_o       (dout_o),
    .dout_valid_o (dout_valid_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !dout_valid_o);
endmodule

// File: tb/sdr_burst_engine_tb.sv
`timescale 1ns/1ps
module sdr_burst_engine_tb;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic [2:0]  cmd = NOP;
  logic [3:0]  col = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        dout_valid;

  int nvec = 0, nfail = 0, valid_seen = 0;
  logic [15:0] exp_mem [16];
  logic [15:0] exp_q [$];
  string       req_q [$];

  always #2.5 clk = ~clk;

  sdr_burst_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cmd_i(cmd),
    .col_i(col), .din_i(din), .dout_o(dout), .dout_valid_o(dout_valid)
  );

  function automatic logic [3:0] baddr(input logic [3:0] c, input int i);
    return {c[3:2], 2'(int'(c[1:0]) + i)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected word for every valid output cycle
  always @(negedge clk) begin
    if (rst_n && dout_valid) begin
      valid_seen++;
      nvec++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R3: unexpected valid output actual %0h expected none", dout);
      end else begin
        logic [15:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (dout !== e) begin
          nfail++;
          $display("FAIL %s: dout actual %0h expected %0h", r, dout, e);
        end
      end
    end
  end

  task automatic drive(input logic [2:0] c, input logic [3:0] a, input logic [15:0] d, input logic k);
    @(negedge clk);
    cmd = c; col = a; din = d; cke = k;
  endtask

  task automatic drain(input string req);
    repeat (4) drive(NOP, 4'd0, 16'h0, 1'b1);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // read burst; clock-enable sampled low on edges s..s+nlow-1; optional busy commands
  task automatic rd_burst(input logic [3:0] c, input int s, input int nlow, input bit busy, input string req);
    int k = 0;
    for (int e = 0; e < 14; e++) begin
      logic k_en;
      logic [2:0] cc;
      k_en = !(nlow > 0 && e >= s && e < s + nlow);
      if (e > 0 && !(e >= s + 1 && e <= s + nlow)) k++;
      if (k >= 2 && k <= 5 && e > 0 && !(e >= s + 1 && e <= s + nlow)) begin
        exp_q.push_back(exp_mem[baddr(c, k - 2)]);
        req_q.push_back(req);
      end else if (k >= 2 && k <= 5 && e > 0) begin
        exp_q.push_back(exp_mem[baddr(c, k - 2)]);
        req_q.push_back(req);
      end
      cc = (e == 0) ? RD : NOP;
      if (busy && e == 1) drive(WR, c, 16'hEEEE, k_en);
      else if (busy && e == 2) drive(PRE, c, 16'h0, k_en);
      else drive(cc, c, 16'h0, k_en);
    end
    drain(req);
  endtask

  task automatic wr_burst(input logic [3:0] c, input int s, input int nlow, input logic [15:0] base);
    int b = 0;
    for (int e = 0; e < 10 + nlow; e++) begin
      logic k_en, adv;
      k_en = !(nlow > 0 && e >= s && e < s + nlow);
      adv  = !(e >= s + 1 && e <= s + nlow);
      if (e == 0) begin
        exp_mem[baddr(c, 0)] = base;
        b = 1;
        drive(WR, c, base, k_en);
      end else if (adv && b < 4) begin
        exp_mem[baddr(c, b)] = base + 16'(b);
        drive(NOP, c, base + 16'(b), k_en);
        b++;
      end else begin
        drive(NOP, c, 16'hDEAD, k_en);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dout_valid == 1'b0, "R1", dout_valid, 0);

    // R1 R2: row closed after reset, read ignored
    snap = valid_seen;
    drive(RD, 4'd0, 16'h0, 1'b1);
    repeat (8) drive(NOP, 4'd0, 16'h0, 1'b1);
    check(valid_seen == snap, "R2", valid_seen - snap, 0);

    drive(ACT, 4'd0, 16'h0, 1'b1);
    // R4 R5: fill all columns with wrapping bursts
    wr_burst(4'd0, 0, 0, 16'h1100);
    wr_burst(4'd6, 0, 0, 16'h2200);
    wr_burst(4'd9, 0, 0, 16'h3300);
    wr_burst(4'd15, 0, 0, 16'h4400);

    rd_burst(4'd0, 0, 0, 0, "R3");
    rd_burst(4'd6, 0, 0, 0, "R5");
    rd_burst(4'd11, 0, 0, 0, "R5");
    rd_burst(4'd13, 0, 0, 0, "R4");

    // R6 R7 R8: freezes at several points of a read
    rd_burst(4'd4, 3, 2, 0, "R8");
    rd_burst(4'd7, 0, 1, 0, "R6");
    rd_burst(4'd10, 2, 4, 0, "R7");
    rd_burst(4'd1, 5, 3, 0, "R8");

    // R9: freeze in the middle of a write, then read back
    wr_burst(4'd2, 1, 2, 16'h5500);
    wr_burst(4'd12, 0, 3, 16'h6600);
    rd_burst(4'd0, 0, 0, 0, "R9");
    rd_burst(4'd12, 0, 0, 0, "R9");

    // R10: commands on frozen edges are dropped
    snap = valid_seen;
    drive(NOP, 4'd0, 16'h0, 1'b0);
    drive(PRE, 4'd0, 16'h0, 1'b0);
    drive(WR, 4'd3, 16'hBADD, 1'b0);
    drive(RD, 4'd3, 16'h0, 1'b0);
    drive(RD, 4'd3, 16'h0, 1'b1);
    repeat (8) drive(NOP, 4'd0, 16'h0, 1'b1);
    check(valid_seen == snap, "R10", valid_seen - snap, 0);
    rd_burst(4'd3, 0, 0, 0, "R10");

    // R12: write and close row during a read burst are ignored
    rd_burst(4'd4, 0, 0, 1, "R12");
    rd_burst(4'd4, 0, 0, 0, "R12");

    // R2: close row, then read is ignored
    drive(PRE, 4'd0, 16'h0, 1'b1);
    snap = valid_seen;
    drive(RD, 4'd5, 16'h0, 1'b1);
    repeat (8) drive(NOP, 4'd0, 16'h0, 1'b1);
    check(valid_seen == snap, "R2", valid_seen - snap, 0);

    // R11: low clock-enable with row closed, open row still decoded
    drive(NOP, 4'd0, 16'h0, 1'b0);
    drive(NOP, 4'd0, 16'h0, 1'b0);
    drive(ACT, 4'd0, 16'h0, 1'b0);
    drive(NOP, 4'd0, 16'h0, 1'b1);
    rd_burst(4'd6, 0, 0, 0, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule